// File: doc/BRIEF.md
# Debug-Control Scan Register with Core Reset Hold

This block is one data register behind a JTAG test access port. It is reached when the instruction register selects the debug-control instruction. Its 35-bit scan chain carries three things: a 32-bit debug control/status word, a break-request flag and a hold-reset flag. Capture, shift and update follow the strobes of the TAP state machine and are clocked by TCK. The block drives the control word and the break flag to the debug logic of the core.

The block also drives the reset seen by the core. That reset is the external reset pin ORed with the hold-reset flag. A debugger sets the flag before the pin is released, or while it is still asserted. The core then stays in reset after the pin goes inactive, which gives the debugger time to load handler code into instruction memory. A later update that carries a zero in the hold position releases the core, and execution begins at the reset vector.

Capture forces a one into the hold position. A capture followed at once by an update therefore sets the hold and clears the break flag, and it writes the control word back unchanged.

Top module: `dbg_ctl_dr`

## Requirements
- R1: A capture while selected loads the chain as follows: bits 34:3 take the current control word, bit 2 (break) takes 0, bit 1 (hold) takes 1 and bit 0 takes 0.
- R2: A shift while selected moves the chain one place toward TDO on a rising TCK edge. TDI enters bit 34 and bit 0 feeds TDO, so 35 shifts exchange the whole chain, with bit 0 leaving first.
- R3: TDO changes only on a falling TCK edge, where it takes the value of bit 0 of the chain.
- R4: An update while selected writes chain bits 34:3 to the control word, bit 2 to the break flag and bit 1 to the hold flag. Bit 0 has no effect.
- R5: A capture followed directly by an update, with no shift between them, sets the hold flag, clears the break flag and leaves the control word unchanged.
- R6: The core reset output is high whenever the external reset pin is high or the hold flag is set. The pin never clears the hold flag, so the core stays in reset after the pin is released if the hold was set earlier or while the pin was asserted.
- R7: The only way to clear the hold flag, other than a test-logic reset, is an update that carries 0 in bit 1. Clearing it drops the core reset when the pin is low.
- R8: While the register is not selected, capture, shift and update strobes leave the control word, the break flag and the hold flag unchanged.
- R9: A low level on trst_n asynchronously clears the chain, the control word, both flags and TDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| sel | input | 1 | High while the current instruction selects this register |
| capture_dr | input | 1 | TAP is in the capture state for data registers |
| shift_dr | input | 1 | TAP is in the shift state for data registers |
| update_dr | input | 1 | TAP is in the update state for data registers |
| tdi | input | 1 | Serial test data in |
| ext_rst | input | 1 | External reset pin, active high |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| ctl_word | output | 32 | Debug control/status word |
| brk_req | output | 1 | Break-request flag |
| core_rst | output | 1 | Reset to the core, active high |

## Verification
The bench goes after the bare capture-then-update path. A design that does not force the hold bit on capture, or that fails to zero the break bit, would leave the core running or keep a stale break request. It also checks the pin sequences: holding the pin during the hold and then releasing it, and pulsing the pin while the hold is set. A design that lets the pin clear the flag, or that drives the core reset from the pin alone, drops the core out of reset too early. Finally it checks the scan order, the falling-edge timing of TDO and strobes that arrive while the register is not selected. A design that gets any of these wrong reads back a shifted or reversed word, races the TDO sample or corrupts the control word.

// File: rtl/dbg_dr_pkg.sv
package dbg_dr_pkg;

  // Low field positions; the high field holds the control word.
  localparam int IGN_POS  = 0;
  localparam int HOLD_POS = 1;
  localparam int BRK_POS  = 2;
  localparam int FLAG_N   = 3;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } dr_op_e;

  // The register acts only when selected. At most one TAP strobe is
  // legal at a time; capture wins, then shift, then update.
  function automatic dr_op_e decode_op(input logic sel, input logic cap,
                                       input logic sh, input logic up);
    if (!sel)     return OP_IDLE;
    else if (cap) return OP_CAPTURE;
    else if (sh)  return OP_SHIFT;
    else if (up)  return OP_UPDATE;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/dbg_dr_chain.sv
module dbg_dr_chain #(
  parameter int WORD_W = 32,
  localparam int CHAIN_W = WORD_W + dbg_dr_pkg::FLAG_N
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  dbg_dr_pkg::dr_op_e   op,
  input  logic                 tdi,
  input  logic [WORD_W-1:0]    cur_word,
  output logic [CHAIN_W-1:0]   chain,
  output logic                 tdo
);
  import dbg_dr_pkg::*;

  // The image captured from the current word: hold forced to one,
  // break and the unused bit cleared.
  function automatic logic [CHAIN_W-1:0] capture_image(input logic [WORD_W-1:0] w);
    logic [CHAIN_W-1:0] img;
    img = '0;
    img[CHAIN_W-1:FLAG_N] = w;
    img[HOLD_POS] = 1'b1;
    return img;
  endfunction

  // One step toward TDO; serial input enters at the top.
  function automatic logic [CHAIN_W-1:0] shift_step(input logic [CHAIN_W-1:0] c,
                                                    input logic din);
    return {din, c[CHAIN_W-1:1]};
  endfunction

  logic [CHAIN_W-1:0] chain_q;
  logic               tdo_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      chain_q <= '0;
    end else begin
      case (op)
        OP_CAPTURE: chain_q <= capture_image(cur_word);
        OP_SHIFT:   chain_q <= shift_step(chain_q, tdi);
        default:    chain_q <= chain_q;
      endcase
    end
  end

  // Output stage on the falling edge, half a cycle after the shift.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo_q <= 1'b0;
    else         tdo_q <= chain_q[IGN_POS];
  end

  assign chain = chain_q;
  assign tdo   = tdo_q;
endmodule

// File: rtl/dbg_dr_latch.sv
module dbg_dr_latch #(
  parameter int WORD_W = 32
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  dbg_dr_pkg::dr_op_e   op,
  input  logic [WORD_W-1:0]    new_word,
  input  logic                 new_brk,
  input  logic                 new_hold,
  output logic [WORD_W-1:0]    word,
  output logic                 brk,
  output logic                 hold
);
  import dbg_dr_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic              brk_q;
  logic              hold_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      word_q <= '0;
      brk_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (op == OP_UPDATE) begin
      word_q <= new_word;
      brk_q  <= new_brk;
      hold_q <= new_hold;
    end
  end

  assign word = word_q;
  assign brk  = brk_q;
  assign hold = hold_q;
endmodule

// File: rtl/dbg_core_rst.sv
module dbg_core_rst (
  input  logic ext_rst,
  input  logic hold,
  output logic core_rst
);
  // The pin and the held flag each keep the core in reset.
  always_comb core_rst = ext_rst | hold;
endmodule

// File: rtl/dbg_ctl_dr.sv
module dbg_ctl_dr #(
  parameter int WORD_W = 32,
  localparam int CHAIN_W = WORD_W + dbg_dr_pkg::FLAG_N
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic              ext_rst,
  output logic              tdo,
  output logic [WORD_W-1:0] ctl_word,
  output logic              brk_req,
  output logic              core_rst
);
  import dbg_dr_pkg::*;

  // Named internal events, visible to the bound checker.
  dr_op_e             op_w;
  logic [CHAIN_W-1:0] chain_w;
  logic               hold_w;
  logic [WORD_W-1:0]  upd_word_w;
  logic               upd_brk_w;
  logic               upd_hold_w;

  assign op_w       = decode_op(sel, capture_dr, shift_dr, update_dr);
  assign upd_word_w = chain_w[CHAIN_W-1:FLAG_N];
  assign upd_brk_w  = chain_w[BRK_POS];
  assign upd_hold_w = chain_w[HOLD_POS];

  dbg_dr_chain #(.WORD_W(WORD_W)) u_chain (
    .tck      (tck),
    .trst_n   (trst_n),
    .op       (op_w),
    .tdi      (tdi),
    .cur_word (ctl_word),
    .chain    (chain_w),
    .tdo      (tdo)
  );

  dbg_dr_latch #(.WORD_W(WORD_W)) u_latch (
    .tck      (tck),
    .trst_n   (trst_n),
    .op       (op_w),
    .new_word (upd_word_w),
    .new_brk  (upd_brk_w),
    .new_hold (upd_hold_w),
    .word     (ctl_word),
    .brk      (brk_req),
    .hold     (hold_w)
  );

  dbg_core_rst u_rst (
    .ext_rst  (ext_rst),
    .hold     (hold_w),
    .core_rst (core_rst)
  );
endmodule

// File: rtl/dbg_ctl_dr_chk.sv
module dbg_ctl_dr_chk #(
  parameter int WORD_W = 32,
  localparam int CHAIN_W = WORD_W + 3
) (
  input logic              tck,
  input logic              trst_n,
  input logic              sel,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              ext_rst,
  input logic              tdo,
  input logic [WORD_W-1:0] ctl_word,
  input logic              brk_req,
  input logic              core_rst,
  input logic [CHAIN_W-1:0] chain,
  input logic              hold
);
  logic do_cap, do_sh, do_up, do_upd_any;
  assign do_cap     = sel && capture_dr;
  assign do_sh      = sel && !capture_dr && shift_dr;
  assign do_up      = sel && !capture_dr && !shift_dr && update_dr;
  assign do_upd_any = sel && update_dr;

  // R1: capture image
  a_r1_capture_image: assert property (@(posedge tck) disable iff (!trst_n)
    do_cap |=> (chain[2:0] == 3'b010) && (chain[CHAIN_W-1:3] == $past(ctl_word)));

  // R2: shift toward TDO
  a_r2_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
    do_sh |=> chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1]));

  // R3: TDO as seen at the rising edge equals the chain LSB set up half a cycle earlier
  a_r3_tdo_half_cycle: assert property (@(posedge tck) disable iff (!trst_n)
    tdo == chain[0]);

  // R4: update copies the fields
  a_r4_update_fields: assert property (@(posedge tck) disable iff (!trst_n)
    do_up |=> (ctl_word == $past(chain[CHAIN_W-1:3])) && (brk_req == $past(chain[2]))
              && (hold == $past(chain[1])));

  // R6: either source holds the core in reset
  a_r6_pin_resets: assert property (@(posedge tck) disable iff (!trst_n)
    ext_rst |-> core_rst);
  a_r6_hold_resets: assert property (@(posedge tck) disable iff (!trst_n)
    hold |-> core_rst);

  // R7: hold only falls after a selected update
  a_r7_hold_clear_src: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(hold) |-> $past(do_upd_any));

  // R8: nothing changes without a selected update
  a_r8_idle_stable: assert property (@(posedge tck) disable iff (!trst_n)
    !do_upd_any |=> $stable(ctl_word) && $stable(brk_req) && $stable(hold));
endmodule

bind dbg_ctl_dr dbg_ctl_dr_chk #(.WORD_W(WORD_W)) u_dbg_ctl_dr_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .sel        (sel),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .ext_rst    (ext_rst),
  .tdo        (tdo),
  .ctl_word   (ctl_word),
  .brk_req    (brk_req),
  .core_rst   (core_rst),
  .chain      (chain_w),
  .hold       (hold_w)
);

// File: tb/test_dbg_ctl_dr.sv
module test_dbg_ctl_dr;
  localparam int WW = 32;
  localparam int CW = WW + 3;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          sel = 1'b1;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic          update_dr = 1'b0;
  logic          tdi = 1'b0;
  logic          ext_rst = 1'b0;
  logic          tdo;
  logic [WW-1:0] ctl_word;
  logic          brk_req;
  logic          core_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dbg_ctl_dr #(.WORD_W(WW)) i_dbg_ctl_dr (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .ext_rst(ext_rst),
    .tdo(tdo), .ctl_word(ctl_word), .brk_req(brk_req), .core_rst(core_rst)
  );

  always #5 tck = ~tck;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected chain image: word on top, then break, hold, unused bit.
  function automatic logic [CW-1:0] pack(input logic [WW-1:0] w, input logic b,
                                         input logic h, input logic z);
    return {w, b, h, z};
  endfunction

  task automatic strobe(input logic c, input logic s, input logic u, input logic d);
    @(negedge tck); #1;
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
    @(posedge tck); #1;
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  // Capture, full exchange, update. Returns the bits read on TDO.
  task automatic scan(input logic [CW-1:0] din, output logic [CW-1:0] dout);
    strobe(1, 0, 0, 0);
    for (int i = 0; i < CW; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      shift_dr = 1; tdi = din[i];
      @(posedge tck); #1;
      shift_dr = 0;
    end
    strobe(0, 0, 1, 0);
  endtask

  logic [WW-1:0] w_a = 32'hA5C3_0F1E;
  logic [WW-1:0] w_b = 32'h1357_9BDF;

  task automatic t_reset();
    chk(ctl_word, 0, "R9 word after reset");
    chk(brk_req, 0, "R9 brk after reset");
    chk(core_rst, 0, "R9 core_rst after reset");
    chk(tdo, 0, "R9 tdo after reset");
  endtask

  task automatic t_write_read();
    logic [CW-1:0] got;
    scan(pack(w_a, 1, 0, 1), got);
    chk(got, pack(0, 0, 1, 0), "R1 capture image from reset word");
    chk(ctl_word, w_a, "R4 word written");
    chk(brk_req, 1, "R4 brk written");
    chk(core_rst, 0, "R6 no hold no pin");
    scan(pack(w_a, 1, 0, 0), got);
    chk(got, pack(w_a, 0, 1, 0), "R2 R1 readback order");
    chk(ctl_word, w_a, "R4 bit0 ignored");
  endtask

  task automatic t_tdo_edge();
    strobe(1, 0, 0, 0);
    @(negedge tck); #1;
    chk(tdo, 0, "R3 tdo after capture");
    shift_dr = 1; tdi = 0;
    @(posedge tck); #1;
    shift_dr = 0;
    chk(tdo, 0, "R3 tdo held until falling edge");
    @(negedge tck); #1;
    chk(tdo, 1, "R2 R3 hold bit reaches tdo");
  endtask

  task automatic t_bare();
    strobe(1, 0, 0, 0);
    strobe(0, 0, 1, 0);
    chk(ctl_word, w_a, "R5 word kept");
    chk(brk_req, 0, "R5 brk cleared");
    chk(core_rst, 1, "R5 hold set core in reset");
  endtask

  task automatic t_pin_with_hold();
    @(negedge tck); #1 ext_rst = 1;
    @(negedge tck); #1 ext_rst = 0;
    @(negedge tck); #1;
    chk(core_rst, 1, "R6 pin release keeps hold");
  endtask

  task automatic t_unselected();
    logic [CW-1:0] got;
    sel = 0;
    scan(pack(~w_a, 1, 0, 0), got);
    sel = 1;
    chk(ctl_word, w_a, "R8 word unchanged");
    chk(brk_req, 0, "R8 brk unchanged");
    chk(core_rst, 1, "R8 hold unchanged");
  endtask

  task automatic t_release();
    logic [CW-1:0] got;
    scan(pack(w_b, 0, 0, 0), got);
    chk(core_rst, 0, "R7 hold cleared releases core");
    chk(ctl_word, w_b, "R7 word with release");
  endtask

  task automatic t_pin_only_and_hold_during_pin();
    @(negedge tck); #1 ext_rst = 1;
    @(negedge tck); #1;
    chk(core_rst, 1, "R6 pin alone resets");
    strobe(1, 0, 0, 0);
    strobe(0, 0, 1, 0);
    @(negedge tck); #1 ext_rst = 0;
    @(negedge tck); #1;
    chk(core_rst, 1, "R6 hold set during pin survives release");
    chk(ctl_word, w_b, "R5 word kept during pin");
  endtask

  task automatic t_trst();
    logic [CW-1:0] got;
    scan(pack(w_b, 1, 1, 0), got);
    chk(brk_req, 1, "R4 brk set before trst");
    @(negedge tck); #1 trst_n = 0;
    #2 trst_n = 1;
    #1;
    chk(core_rst, 0, "R9 trst clears hold");
    chk(ctl_word, 0, "R9 trst clears word");
    chk(brk_req, 0, "R9 trst clears brk");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    #1 trst_n = 1;
    #1;
    t_reset();
    t_write_read();
    t_tdo_edge();
    t_bare();
    t_pin_with_hold();
    t_unselected();
    t_release();
    t_pin_only_and_hold_during_pin();
    t_trst();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule